// File: doc/BRIEF.md
# Filter Step Sequencer

This block steps through a small stored program that drives a chain of decimating FIR stages. Each program step is one 64-bit word. A step can do one of three things. It can stall until enough input samples have arrived. It can launch one filter computation on an external engine. It can move control to another step. A fourth opcode simply advances to the next step.

When a filter step launches, the block pulses a start strobe and presents the step's parameters. It then waits for the engine's done handshake. After that it spends one clock writing the result, either into a later step's input or to the final output path.

The program is loaded through an address/data/write-enable port, and only while the sequencer is held. Input-sample strobes are counted at all times, including while the engine is busy. A meter reports how many clocks each final output cost, so a filter program can be checked against its cycle budget.

Top module: `fir_step_sequencer`

## Requirements
- R1: While `hold` is 1, `cur_step` is 0 and `samples_avail` is 0. `fir_start`, `route_wr` and `final_out` stay 0. Program writes are accepted.
- R2: A program write (`prog_we`=1) made while `hold` is 0 leaves the stored program unchanged.
- R3: A step is a WAIT when bits [63:62] are 0, and its required sample count is in bits [7:0].
  - If `samples_avail` is below that count, `cur_step` stays put.
  - Otherwise the step takes one clock and advances to the next step.
- R4: A step is a JUMP when bits [63:62] are 2. It takes one clock and sets `cur_step` to bits [3:0].
- R5: A step is a FIR when bits [63:62] are 1. It pulses `fir_start` for exactly one clock and presents the fields on the parameter outputs:
  - `fir_sym`: bits [60:59]
  - `fir_half`: bit 58
  - `fir_taps`: bits [57:49]
  - `fir_decim`: bits [48:45]
  - `fir_blk`: bits [44:42]
  - `fir_dbase`: bits [41:32]
  - `fir_cbase`: bits [31:22]
  - `fir_stride`: bits [21:18]
- R6: After `fir_start`, the sequencer waits until `eng_done` is 1. In the clock that follows, it pulses one of two outputs:
  - `route_wr`, with `route_step` equal to bits [16:13], when bit 17 is 0;
  - `final_out`, when bit 17 is 1.
  It then advances to the next step. `eng_done` outside that waiting state has no effect.
- R7: Each clock with `in_strobe`=1 and `hold`=0 adds one to `samples_avail`, even while the engine is busy. The count saturates at its maximum (255 by default).
- R8: A FIR step with bit 61 set clears `samples_avail` in its start clock. A strobe in that same clock leaves the count at 1.
- R9: `cycles_per_out` reports the cost of each final output, updated in the clock after `final_out` pulses. It counts the clocks since the previous `final_out` or since `hold` fell, including the `final_out` clock itself, and saturates.
- R10: Opcode 3 advances one step in one clock. Advancing from the last step wraps to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Holds the sequencer at step 0 and enables program loading |
| prog_we | input | 1 | Program write enable |
| prog_addr | input | PC_W (4) | Program write step index |
| prog_wdata | input | 64 | Program word |
| in_strobe | input | 1 | One new input sample has arrived |
| eng_done | input | 1 | Filter engine finished the current computation |
| fir_start | output | 1 | Launch one filter computation |
| fir_sym | output | 2 | Symmetry type |
| fir_half | output | 1 | Halfband flag |
| fir_taps | output | 9 | Tap count |
| fir_decim | output | 4 | Decimation factor |
| fir_blk | output | 3 | Data block size code |
| fir_dbase | output | 10 | Data block start |
| fir_cbase | output | 10 | Coefficient block start |
| fir_stride | output | 4 | Step size |
| route_wr | output | 1 | Result written into a later step's input |
| route_step | output | 4 | Step receiving the result |
| final_out | output | 1 | Result sent to the final output path |
| cur_step | output | PC_W (4) | Current step index |
| samples_avail | output | CNT_W (8) | Pending input-sample count |
| cycles_per_out | output | CYC_W (16) | Clocks spent on the last final output |

## Verification
The bound checker watches several behaviours on every clock:
- the quiet outputs during hold;
- the single-cycle start pulse;
- routing that happens only after a done accepted in the busy state, and never to both destinations at once;
- stalls in unmet WAIT steps and JUMP landing sites;
- one-per-strobe counting and the clear-on-start rule.

Some behaviours need scenarios that only the bench can drive:
- program loads being refused while running;
- saturation of the sample count;
- wrap of the step index;
- exact per-output clock totals under steady and starved input.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int WORD_W = 64;
  localparam int NEED_W = 8;
  localparam int DST_W  = 4;

  typedef enum logic [1:0] {
    OP_WAIT = 2'd0,
    OP_FIR  = 2'd1,
    OP_JUMP = 2'd2,
    OP_SKIP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_EXEC  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ROUTE = 2'd2
  } st_e;

  typedef struct packed {
    logic             clr;
    logic [1:0]       sym;
    logic             half;
    logic [8:0]       taps;
    logic [3:0]       decim;
    logic [2:0]       blk;
    logic [9:0]       dbase;
    logic [9:0]       cbase;
    logic [3:0]       stride;
    logic             to_final;
    logic [DST_W-1:0] dst;
  } fir_t;

  function automatic op_e op_of(input logic [WORD_W-1:0] w);
    return op_e'(w[63:62]);
  endfunction

  function automatic logic [NEED_W-1:0] need_of(input logic [WORD_W-1:0] w);
    return w[NEED_W-1:0];
  endfunction

  function automatic logic [DST_W-1:0] target_of(input logic [WORD_W-1:0] w);
    return w[DST_W-1:0];
  endfunction

  function automatic fir_t fir_of(input logic [WORD_W-1:0] w);
    fir_t f;
    f.clr      = w[61];
    f.sym      = w[60:59];
    f.half     = w[58];
    f.taps     = w[57:49];
    f.decim    = w[48:45];
    f.blk      = w[44:42];
    f.dbase    = w[41:32];
    f.cbase    = w[31:22];
    f.stride   = w[21:18];
    f.to_final = w[17];
    f.dst      = w[16:13];
    return f;
  endfunction
endpackage

// File: rtl/fseq_progmem.sv
module fseq_progmem #(
  parameter int STEPS = 16,
  parameter int WORD_W = 64,
  localparam int PC_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PC_W-1:0]   rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [STEPS];
  logic              wr_hit;

  assign wr_hit  = load_ok && wr_en && (int'(wr_addr) < STEPS);
  assign rd_word = (int'(rd_addr) < STEPS) ? mem[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STEPS; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/fseq_sample_counter.sv
module fseq_sample_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             strobe,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] base, input logic inc);
    return (inc && base != CNT_MAX) ? base + 1'b1 : base;
  endfunction

  logic [CNT_W-1:0] base;
  assign base = clear ? '0 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (hold) count <= '0;
    else           count <= bump(base, strobe);
  end
endmodule

// File: rtl/fseq_cycle_meter.sv
module fseq_cycle_meter #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             out_evt,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  function automatic logic [CYC_W-1:0] sat_inc(input logic [CYC_W-1:0] v);
    return (v == CYC_MAX) ? v : v + 1'b1;
  endfunction

  logic [CYC_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      cycles  <= '0;
    end else if (hold) begin
      run_cnt <= '0;
    end else if (out_evt) begin
      cycles  <= sat_inc(run_cnt);
      run_cnt <= '0;
    end else begin
      run_cnt <= sat_inc(run_cnt);
    end
  end
endmodule

// File: rtl/fir_step_sequencer.sv
module fir_step_sequencer
  import fseq_pkg::*;
#(
  parameter int STEPS = 16,
  parameter int CNT_W = 8,
  parameter int CYC_W = 16,
  localparam int PC_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [WORD_W-1:0] prog_wdata,
  input  logic              in_strobe,
  input  logic              eng_done,
  output logic              fir_start,
  output logic [1:0]        fir_sym,
  output logic              fir_half,
  output logic [8:0]        fir_taps,
  output logic [3:0]        fir_decim,
  output logic [2:0]        fir_blk,
  output logic [9:0]        fir_dbase,
  output logic [9:0]        fir_cbase,
  output logic [3:0]        fir_stride,
  output logic              route_wr,
  output logic [DST_W-1:0]  route_step,
  output logic              final_out,
  output logic [PC_W-1:0]   cur_step,
  output logic [CNT_W-1:0]  samples_avail,
  output logic [CYC_W-1:0]  cycles_per_out
);
  function automatic logic [PC_W-1:0] step_after(input logic [PC_W-1:0] p);
    return (int'(p) == STEPS - 1) ? '0 : p + 1'b1;
  endfunction

  st_e               state;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] word;
  op_e               op;
  fir_t              fld;
  logic              run;
  logic              in_exec;
  // named internal events, shared with the checker
  logic              fir_evt;
  logic              jump_evt;
  logic              wait_ok;
  logic              wait_block;
  logic              skip_evt;
  logic              busy_w;
  logic              finish_evt;
  logic              route_evt;
  logic              clr_evt;
  logic [PC_W-1:0]   jump_tgt;

  fseq_progmem #(.STEPS(STEPS), .WORD_W(WORD_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ok (hold),
    .wr_en   (prog_we),
    .wr_addr (prog_addr),
    .wr_data (prog_wdata),
    .rd_addr (pc),
    .rd_word (word)
  );

  assign op       = op_of(word);
  assign fld      = fir_of(word);
  assign jump_tgt = PC_W'(target_of(word));
  assign run      = !hold;
  assign in_exec  = run && (state == ST_EXEC);
  assign busy_w   = (state == ST_BUSY);

  assign fir_evt    = in_exec && (op == OP_FIR);
  assign jump_evt   = in_exec && (op == OP_JUMP);
  assign skip_evt   = in_exec && (op == OP_SKIP);
  assign wait_ok    = in_exec && (op == OP_WAIT) && (int'(samples_avail) >= int'(need_of(word)));
  assign wait_block = in_exec && (op == OP_WAIT) && !wait_ok;
  assign finish_evt = run && busy_w && eng_done;
  assign route_evt  = run && (state == ST_ROUTE);
  assign clr_evt    = fir_evt && fld.clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_EXEC;
      pc    <= '0;
    end else if (hold) begin
      state <= ST_EXEC;
      pc    <= '0;
    end else begin
      unique case (state)
        ST_EXEC: begin
          if (fir_evt)                    state <= ST_BUSY;
          else if (jump_evt)              pc <= jump_tgt;
          else if (wait_ok || skip_evt)   pc <= step_after(pc);
        end
        ST_BUSY: begin
          if (finish_evt) state <= ST_ROUTE;
        end
        ST_ROUTE: begin
          state <= ST_EXEC;
          pc    <= step_after(pc);
        end
        default: state <= ST_EXEC;
      endcase
    end
  end

  fseq_sample_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .strobe (in_strobe),
    .clear  (clr_evt),
    .count  (samples_avail)
  );

  fseq_cycle_meter #(.CYC_W(CYC_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .out_evt (final_out),
    .cycles  (cycles_per_out)
  );

  assign fir_start  = fir_evt;
  assign fir_sym    = fld.sym;
  assign fir_half   = fld.half;
  assign fir_taps   = fld.taps;
  assign fir_decim  = fld.decim;
  assign fir_blk    = fld.blk;
  assign fir_dbase  = fld.dbase;
  assign fir_cbase  = fld.cbase;
  assign fir_stride = fld.stride;
  assign route_wr   = route_evt && !fld.to_final;
  assign final_out  = route_evt && fld.to_final;
  assign route_step = fld.dst;
  assign cur_step   = pc;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int PC_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             in_strobe,
  input logic             eng_done,
  input logic             fir_start,
  input logic             route_wr,
  input logic             final_out,
  input logic [PC_W-1:0]  cur_step,
  input logic [CNT_W-1:0] samples_avail,
  input logic             busy_w,
  input logic             clr_evt,
  input logic             jump_evt,
  input logic [PC_W-1:0]  jump_tgt,
  input logic             wait_block
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!fir_start && !route_wr && !final_out));

  a_r3_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wait_block |=> (cur_step == $past(cur_step)));

  a_r4_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |=> (cur_step == $past(jump_tgt)));

  a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    fir_start |=> !fir_start);

  a_r6_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(route_wr && final_out));

  a_r6_route_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (route_wr || final_out) |-> $past(busy_w && eng_done));

  a_r7_strobe_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !hold && !clr_evt && samples_avail != CNT_MAX)
      |=> (samples_avail == $past(samples_avail) + 1'b1));

  a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (samples_avail == CNT_W'($past(in_strobe))));
endmodule

bind fir_step_sequencer fseq_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hold          (hold),
  .in_strobe     (in_strobe),
  .eng_done      (eng_done),
  .fir_start     (fir_start),
  .route_wr      (route_wr),
  .final_out     (final_out),
  .cur_step      (cur_step),
  .samples_avail (samples_avail),
  .busy_w        (busy_w),
  .clr_evt       (clr_evt),
  .jump_evt      (jump_evt),
  .jump_tgt      (jump_tgt),
  .wait_block    (wait_block)
);

// File: tb/fir_step_sequencer_test.sv
module fir_step_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b1;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [63:0] prog_wdata = '0;
  logic        in_strobe = 1'b0;
  logic        eng_done = 1'b0;
  logic        fir_start, fir_half, route_wr, final_out;
  logic [1:0]  fir_sym;
  logic [8:0]  fir_taps;
  logic [3:0]  fir_decim, fir_stride, route_step, cur_step;
  logic [2:0]  fir_blk;
  logic [9:0]  fir_dbase, fir_cbase;
  logic [7:0]  samples_avail;
  logic [15:0] cycles_per_out;

  always #2.5 clk = ~clk;

  fir_step_sequencer uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .in_strobe(in_strobe), .eng_done(eng_done),
    .fir_start(fir_start), .fir_sym(fir_sym), .fir_half(fir_half), .fir_taps(fir_taps),
    .fir_decim(fir_decim), .fir_blk(fir_blk), .fir_dbase(fir_dbase), .fir_cbase(fir_cbase),
    .fir_stride(fir_stride), .route_wr(route_wr), .route_step(route_step),
    .final_out(final_out), .cur_step(cur_step), .samples_avail(samples_avail),
    .cycles_per_out(cycles_per_out)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [63:0] prog [16];
  int m_state = 0;  // 0 execute, 1 engine busy, 2 write result
  int m_pc = 0, m_avail = 0, m_cyc = 0, m_cpo = 0, m_eng = 0;
  bit clr_seen = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] w_fir(input bit clr, input int sym, input bit half, input int taps,
      input int dec, input int blk, input int db, input int cb, input int st, input bit fin, input int dst);
    return {2'b01, clr, 2'(sym), half, 9'(taps), 4'(dec), 3'(blk), 10'(db), 10'(cb), 4'(st), fin, 4'(dst), 13'd0};
  endfunction
  function automatic logic [63:0] w_wait(input int n);  return {2'b00, 54'd0, 8'(n)}; endfunction
  function automatic logic [63:0] w_jump(input int t);  return {2'b10, 58'd0, 4'(t)}; endfunction
  function automatic logic [63:0] w_skip();             return {2'b11, 62'd0}; endfunction

  // one clock: compare outputs against the model, drive inputs, advance the model
  task automatic tick(input bit h, input bit s, input bit sd, input bit we, input int wa, input logic [63:0] wd);
    logic [63:0] w;
    int op, need, lat;
    bit e_start, e_rw, e_fin, dn, fin_now, clr_now;
    w = prog[m_pc];
    op = int'(w[63:62]);
    e_start = !hold && m_state == 0 && op == 1;
    e_rw  = !hold && m_state == 2 && !w[17];
    e_fin = !hold && m_state == 2 && w[17];
    chk("R5", "fir_start", fir_start, e_start);
    chk("R6", "route_wr", route_wr, e_rw);
    chk("R6", "final_out", final_out, e_fin);
    chk("R3", "cur_step", cur_step, m_pc);
    chk("R7", "samples_avail", samples_avail, m_avail);
    chk("R9", "cycles_per_out", cycles_per_out, m_cpo);
    if (clr_seen) begin
      chk("R8", "avail after clearing start with strobe", samples_avail, 1);
      clr_seen = 0;
    end
    if (e_start) begin
      chk("R5", "fir_sym", fir_sym, w[60:59]);
      chk("R5", "fir_half", fir_half, w[58]);
      chk("R5", "fir_taps", fir_taps, w[57:49]);
      chk("R5", "fir_decim", fir_decim, w[48:45]);
      chk("R5", "fir_blk", fir_blk, w[44:42]);
      chk("R5", "fir_dbase", fir_dbase, w[41:32]);
      chk("R5", "fir_cbase", fir_cbase, w[31:22]);
      chk("R5", "fir_stride", fir_stride, w[21:18]);
    end
    if (e_rw) chk("R6", "route_step", route_step, w[16:13]);

    dn = (m_state == 1 && m_eng == 1) || (sd && m_state != 1);
    hold = h; in_strobe = s; eng_done = dn;
    prog_we = we; prog_addr = 4'(wa); prog_wdata = wd;

    fin_now = !h && m_state == 2 && w[17];
    clr_now = !h && m_state == 0 && op == 1 && w[61];
    if (clr_now && s) clr_seen = 1;
    if (h) begin
      if (we) prog[wa] = wd;
      m_state = 0; m_pc = 0; m_avail = 0; m_cyc = 0;
    end else begin
      need = int'(w[7:0]);
      case (m_state)
        0: case (op)
             0: if (m_avail >= need) m_pc = (m_pc + 1) % 16;
             1: begin
                  lat = (int'(w[57:49]) + 1) / 2;
                  m_eng = (lat < 1) ? 1 : lat;
                  m_state = 1;
                end
             2: m_pc = int'(w[3:0]);
             default: m_pc = (m_pc + 1) % 16;
           endcase
        1: if (dn) m_state = 2; else m_eng--;
        default: begin m_state = 0; m_pc = (m_pc + 1) % 16; end
      endcase
      m_avail = clr_now ? 0 : m_avail;
      if (s && m_avail < 255) m_avail++;
      if (fin_now) begin
        m_cpo = (m_cyc + 1 > 65535) ? 65535 : m_cyc + 1;
        m_cyc = 0;
      end else if (m_cyc < 65535) m_cyc++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit s, input bit sd);
    tick(1'b0, s, sd, 1'b0, 0, '0);
  endtask

  task automatic load(input int a, input logic [63:0] d);
    tick(1'b1, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) prog[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "fir_start at reset", fir_start, 0);
    chk("R1", "cur_step at reset", cur_step, 0);
    chk("R1", "samples_avail at reset", samples_avail, 0);
    chk("R1", "cycles_per_out at reset", cycles_per_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: strobes under hold are not counted
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b1, 1'b0, 0, '0);
    chk("R1", "avail held at zero", samples_avail, 0);

    // program A: wait 2, halfband with clear to step 2, final FIR, jump to 0
    load(0, w_wait(2));
    load(1, w_fir(1, 0, 1, 19, 2, 5, 0, 18, 1, 0, 2));
    load(2, w_fir(0, 1, 0, 30, 1, 6, 32, 64, 1, 1, 0));
    load(3, w_jump(0));

    // continuous input: steady budget 1 + (1+10+1) + (1+15+1) + 1 = 31 (R9)
    for (int i = 0; i < 160; i++) run(1'b1, 1'b0);
    chk("R9", "steady cycles per output", cycles_per_out, 31);

    // starved input with spurious done pulses (R3, R6, R7)
    for (int i = 0; i < 600; i++) run(i % 23 == 0, i % 5 == 2);

    // R2: write while running is ignored
    tick(1'b0, 1'b1, 1'b0, 1'b1, 2, w_fir(0, 0, 0, 7, 1, 1, 1, 1, 1, 1, 0));
    for (int i = 0; i < 200; i++) begin
      if (fir_start && cur_step == 4'd2) begin
        chk("R2", "taps after refused write", fir_taps, 30);
        break;
      end
      run(1'b1, 1'b0);
    end

    // program B: wait 255, then skips through to wrap
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, 0, '0);
    load(0, w_wait(255));
    for (int a = 1; a < 16; a++) load(a, w_skip());
    for (int i = 0; i < 300; i++) run(1'b1, 1'b0);
    chk("R7", "saturated count", samples_avail, 255);
    for (int i = 0; i < 40; i++) begin
      if (cur_step == 4'd15) break;
      run(1'b1, 1'b0);
    end
    chk("R10", "reached last step", cur_step, 15);
    run(1'b0, 1'b0);
    chk("R10", "wrap to step 0", cur_step, 0);
    for (int i = 0; i < 20; i++) run(1'b0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule